// File: doc/BRIEF.md
# Read-Side Bus Controller with Mailboxes

This block sits on the read side of a dual-clock FIFO. That FIFO also carries two single-word mailbox registers between its two ports. The block takes the port's control inputs: an active-low chip select, a direction select, a clock enable and a mailbox select. From them it decodes, combinationally, whether the 36-bit data pins are driven and which source drives them. The source is either the FIFO output register or mailbox 1. On each rising clock edge it decides which single operation takes place: a FIFO read, a mailbox-1 read, a mailbox-2 write, or nothing.

The pins are modelled as a split pair: `data_i` is what the pins carry in, and `data_o` with `data_oe_o` is what the block drives out. Mailbox 1 is filled from the opposite port through a write strobe. Its active-low full flag is released when this port reads it. Mailbox 2 is filled from the pins and presents a full indication to the opposite port, which clears it. The FIFO storage is outside the block. It supplies its output register value and receives a one-cycle read strobe.

Top module: `port_b_ctrl`

## Requirements
- R1: While `cs_ni` is 1, `data_oe_o` is 0, `data_o` is all zeros, and no clock edge changes any state or raises `fifo_rd_o`.
- R2: With `cs_ni`=0 and `dir_i`=0, `data_oe_o` is 0. A rising edge that also has `en_i`=1 and `mbx_sel_i`=1 loads `data_i` into `mb2_q_o` and sets `mb2_full_o` to 1.
- R3: With `cs_ni`=0 and `dir_i`=0, a rising edge with `en_i`=0 or `mbx_sel_i`=0 leaves `mb2_q_o` and `mb2_full_o` unchanged.
- R4: With `cs_ni`=0, `dir_i`=1 and `mbx_sel_i`=0, `data_oe_o` is 1 and `data_o` equals `fifo_q_i` in the same cycle, without waiting for a clock edge.
- R5: With `cs_ni`=0, `dir_i`=1, `mbx_sel_i`=0 and `en_i`=1 at a rising edge, `fifo_rd_o` is 1 for the following cycle only. It returns to 0 after the next edge unless that edge is also a FIFO read.
- R6: With `cs_ni`=0, `dir_i`=1 and `mbx_sel_i`=1, `data_oe_o` is 1 and `data_o` equals the mailbox-1 contents.
- R7: A rising edge with `cs_ni`=0, `dir_i`=1, `mbx_sel_i`=1 and `en_i`=1 sets `mb1_full_no` to 1 and does not raise `fifo_rd_o`.
- R8: A rising edge with `mb1_wr_i`=1 loads `mb1_wdata_i` into mailbox 1 and drives `mb1_full_no` to 0. This happens even when a mailbox-1 read falls on the same edge.
- R9: A rising edge with `mb2_clr_i`=1 drives `mb2_full_o` to 0 and leaves `mb2_q_o` unchanged. A mailbox-2 write on the same edge wins and leaves the flag at 1.
- R10: While `en_i` is 0, `cs_ni`, `dir_i` and `mbx_sel_i` may take any values across any number of edges without raising `fifo_rd_o` or changing either mailbox.
- R11: While `rst_ni` is 0, `mb1_full_no` is 1, `mb2_full_o` is 0, `fifo_rd_o` is 0, and both mailbox registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| dir_i | input | 1 | 1 = port reads (pins driven), 0 = port writes |
| en_i | input | 1 | Enables the clocked operation |
| mbx_sel_i | input | 1 | 1 = mailbox traffic, 0 = FIFO traffic |
| data_i | input | 36 | Value arriving on the data pins |
| data_o | output | 36 | Value driven onto the data pins |
| data_oe_o | output | 1 | Pin output enable |
| fifo_q_i | input | 36 | FIFO output register value |
| fifo_rd_o | output | 1 | One-cycle FIFO read strobe |
| mb1_wr_i | input | 1 | Mailbox-1 load strobe from the other port |
| mb1_wdata_i | input | 36 | Mailbox-1 load data |
| mb1_full_no | output | 1 | Mailbox-1 full flag, active low |
| mb2_clr_i | input | 1 | Mailbox-2 flag clear from the other port |
| mb2_q_o | output | 36 | Mailbox-2 contents |
| mb2_full_o | output | 1 | Mailbox-2 full indication |

## Verification
All sixteen combinations of chip select, direction, enable and mailbox select are applied, each from a state where mailbox 1 has just been filled. This separates the cases where the pins are driven from those where they are not. It also tells apart the two output sources and shows which of the four operations, if any, fires at the edge. After each edge the bench checks the read strobe, both mailbox flags and the mailbox-2 contents. An idle edge follows, which shows that the strobe lasts one cycle. Directed cases then cover a load and a release landing on the same edge for each mailbox, control lines toggling across several edges with enable low, and reset applied while both mailboxes are loaded.

// File: rtl/port_b_pkg.sv
package port_b_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_FIFO_RD = 2'd1,
    OP_MB1_RD  = 2'd2,
    OP_MB2_WR  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FIFO = 2'd1,
    SRC_MB1  = 2'd2
  } src_e;
endpackage

// File: rtl/port_b_decode.sv
module port_b_decode
  import port_b_pkg::*;
(
  input  logic cs_ni,
  input  logic dir_i,
  input  logic en_i,
  input  logic mbx_sel_i,
  output logic oe_o,
  output src_e src_o,
  output op_e  op_o
);
  always_comb begin
    oe_o  = 1'b0;
    src_o = SRC_NONE;
    op_o  = OP_NONE;
    if (!cs_ni) begin
      if (dir_i) begin
        oe_o = 1'b1;
        if (mbx_sel_i) begin
          src_o = SRC_MB1;
          if (en_i) op_o = OP_MB1_RD;
        end else begin
          src_o = SRC_FIFO;
          if (en_i) op_o = OP_FIFO_RD;
        end
      end else if (en_i && mbx_sel_i) begin
        op_o = OP_MB2_WR;
      end
    end
  end
endmodule

// File: rtl/port_b_mbx_slot.sv
// Single-word mailbox; load has priority over release on the same edge.
module port_b_mbx_slot #(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          release_i,
  output logic [DW-1:0] q_o,
  output logic          full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= '0;
      full_o <= 1'b0;
    end else if (load_i) begin
      q_o    <= load_data_i;
      full_o <= 1'b1;
    end else if (release_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/port_b_ctrl.sv
module port_b_ctrl
  import port_b_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          dir_i,
  input  logic          en_i,
  input  logic          mbx_sel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] fifo_q_i,
  output logic          fifo_rd_o,
  input  logic          mb1_wr_i,
  input  logic [DW-1:0] mb1_wdata_i,
  output logic          mb1_full_no,
  input  logic          mb2_clr_i,
  output logic [DW-1:0] mb2_q_o,
  output logic          mb2_full_o
);
  src_e          src;
  op_e           op;
  logic [DW-1:0] mb1_q;
  logic          mb1_full;

  port_b_decode u_dec (
    .cs_ni    (cs_ni),
    .dir_i    (dir_i),
    .en_i     (en_i),
    .mbx_sel_i(mbx_sel_i),
    .oe_o     (data_oe_o),
    .src_o    (src),
    .op_o     (op)
  );

  port_b_mbx_slot #(.DW(DW)) u_mb1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mb1_wr_i),
    .load_data_i(mb1_wdata_i),
    .release_i  (op == OP_MB1_RD),
    .q_o        (mb1_q),
    .full_o     (mb1_full)
  );

  port_b_mbx_slot #(.DW(DW)) u_mb2 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (op == OP_MB2_WR),
    .load_data_i(data_i),
    .release_i  (mb2_clr_i),
    .q_o        (mb2_q_o),
    .full_o     (mb2_full_o)
  );

  assign mb1_full_no = ~mb1_full;

  always_comb begin
    unique case (src)
      SRC_FIFO: data_o = fifo_q_i;
      SRC_MB1:  data_o = mb1_q;
      default:  data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_rd_o <= 1'b0;
    else         fifo_rd_o <= (op == OP_FIFO_RD);
  end
endmodule

// File: rtl/port_b_ctrl_chk.sv
module port_b_ctrl_chk #(
  parameter int DW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          dir_i,
  input logic          en_i,
  input logic          mbx_sel_i,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic [DW-1:0] fifo_q_i,
  input logic          fifo_rd_o,
  input logic          mb1_wr_i,
  input logic [DW-1:0] mb1_wdata_i,
  input logic          mb1_full_no,
  input logic          mb2_clr_i,
  input logic [DW-1:0] mb2_q_o,
  input logic          mb2_full_o
);
  logic mb2_wr, fifo_rd_req, mb1_rd;
  assign mb2_wr      = !cs_ni && !dir_i && en_i && mbx_sel_i;
  assign fifo_rd_req = !cs_ni && dir_i && en_i && !mbx_sel_i;
  assign mb1_rd      = !cs_ni && dir_i && en_i && mbx_sel_i;

  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!data_oe_o && data_o == '0)); // R1
  AST_MB2_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb2_wr |=> (mb2_full_o && mb2_q_o == $past(data_i))); // R2
  AST_MB2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mb2_wr |=> $stable(mb2_q_o)); // R3
  AST_FIFO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && dir_i && !mbx_sel_i) |-> (data_oe_o && data_o == fifo_q_i)); // R4
  AST_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_req |=> fifo_rd_o); // R5
  AST_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rd_req |=> !fifo_rd_o); // R7
  AST_MB1_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb1_wr_i |=> (!(!cs_ni && dir_i && mbx_sel_i) || data_o == $past(mb1_wdata_i))); // R6
  AST_MB1_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb1_rd && !mb1_wr_i) |=> mb1_full_no); // R7
  AST_MB1_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb1_wr_i |=> !mb1_full_no); // R8
  AST_MB2_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb2_clr_i && !mb2_wr) |=> !mb2_full_o); // R9
  AST_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !mb1_wr_i && !mb2_clr_i) |=> ($stable(mb2_full_o) && $stable(mb1_full_no))); // R10
endmodule

bind port_b_ctrl port_b_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_port_b_ctrl.sv
module sim_port_b_ctrl;
  localparam int DW = 36;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_ni = 1'b1, dir_i = 1'b0, en_i = 1'b0, mbx_sel_i = 1'b0;
  logic [DW-1:0] data_i = '0, fifo_q_i = '0, mb1_wdata_i = '0;
  logic          mb1_wr_i = 1'b0, mb2_clr_i = 1'b0;
  logic [DW-1:0] data_o, mb2_q_o;
  logic          data_oe_o, fifo_rd_o, mb1_full_no, mb2_full_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  port_b_ctrl #(.DW(DW)) u0 (.*);

  // {cs_n, dir, en, sel, exp_oe, exp_src[1:0], exp_op[1:0]}
  // src: 0 none, 1 fifo, 2 mb1; op: 0 none, 1 fifo rd, 2 mb1 rd, 3 mb2 wr
  localparam logic [8:0] VEC [16] = '{
    9'b0000_0_00_00, 9'b0001_0_00_00, 9'b0010_0_00_00, 9'b0011_0_00_11,
    9'b0100_1_01_00, 9'b0101_1_10_00, 9'b0110_1_01_01, 9'b0111_1_10_10,
    9'b1000_0_00_00, 9'b1001_0_00_00, 9'b1010_0_00_00, 9'b1011_0_00_00,
    9'b1100_0_00_00, 9'b1101_0_00_00, 9'b1110_0_00_00, 9'b1111_0_00_00
  };

  logic [DW-1:0] mb1_m, mb2_m;
  logic          mb1_flag_m, mb2_full_m;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_ni = 1'b1; dir_i = 1'b0; en_i = 1'b0; mbx_sel_i = 1'b0;
    mb1_wr_i = 1'b0; mb2_clr_i = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    // R11 reset state
    chk("R11 mb1_full_no", DW'(mb1_full_no), DW'(1));
    chk("R11 mb2_full_o", DW'(mb2_full_o), '0);
    chk("R11 fifo_rd_o", DW'(fifo_rd_o), '0);
    chk("R11 mb2_q_o", mb2_q_o, '0);
    mb2_m = '0; mb2_full_m = 1'b0; mb1_flag_m = 1'b1; mb1_m = '0;
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      logic [8:0] v;
      logic [1:0] e_src, e_op;
      v = VEC[i];
      e_src = v[3:2];
      e_op  = v[1:0];
      // refill mailbox 1 with chip deselected
      @(negedge clk_i);
      idle();
      mb1_wr_i = 1'b1; mb1_wdata_i = {4'hA, 32'(i) * 32'h01010101};
      @(negedge clk_i);
      mb1_wr_i = 1'b0; mb1_m = mb1_wdata_i; mb1_flag_m = 1'b0;
      chk("R8 mb1 loaded flag", DW'(mb1_full_no), '0);
      // apply vector
      {cs_ni, dir_i, en_i, mbx_sel_i} = v[8:5];
      data_i   = {4'h5, 32'(i) + 32'hC0DE0000};
      fifo_q_i = {4'h3, 32'(i) + 32'hF1F00000};
      #1;
      chk("R1/R2/R4/R6 oe", DW'(data_oe_o), DW'(v[4]));
      chk("R1/R4/R6 data_o", data_o,
          e_src == 2'd1 ? fifo_q_i : (e_src == 2'd2 ? mb1_m : '0));
      @(negedge clk_i);
      if (e_op == 2'd3) begin mb2_m = data_i; mb2_full_m = 1'b1; end
      if (e_op == 2'd2) mb1_flag_m = 1'b1;
      chk("R5/R7/R10 fifo_rd_o", DW'(fifo_rd_o), DW'(e_op == 2'd1));
      chk("R7/R8 mb1_full_no", DW'(mb1_full_no), DW'(mb1_flag_m));
      chk("R2/R3 mb2_q_o", mb2_q_o, mb2_m);
      chk("R2/R3 mb2_full_o", DW'(mb2_full_o), DW'(mb2_full_m));
      idle();
      @(negedge clk_i);
      chk("R5 strobe one cycle", DW'(fifo_rd_o), '0);
    end

    // R9 clear alone
    mb2_clr_i = 1'b1;
    @(negedge clk_i);
    mb2_clr_i = 1'b0;
    chk("R9 clear drops flag", DW'(mb2_full_o), '0);
    chk("R9 clear keeps data", mb2_q_o, mb2_m);
    // R9 write and clear on same edge
    cs_ni = 1'b0; dir_i = 1'b0; en_i = 1'b1; mbx_sel_i = 1'b1;
    data_i = 36'h9_8765_4321; mb2_clr_i = 1'b1;
    @(negedge clk_i);
    idle();
    chk("R9 write wins flag", DW'(mb2_full_o), DW'(1));
    chk("R9 write wins data", mb2_q_o, 36'h9_8765_4321);
    mb2_m = 36'h9_8765_4321;

    // R8 load and read on same edge
    cs_ni = 1'b0; dir_i = 1'b1; en_i = 1'b1; mbx_sel_i = 1'b1;
    mb1_wr_i = 1'b1; mb1_wdata_i = 36'hB_CAFE_0001;
    @(negedge clk_i);
    mb1_wr_i = 1'b0; en_i = 1'b0;
    #1;
    chk("R8 load wins flag", DW'(mb1_full_no), '0);
    chk("R6 new mb1 on pins", data_o, 36'hB_CAFE_0001);
    chk("R7 no strobe on mb1 read", DW'(fifo_rd_o), '0);

    // R10 enable low while selects toggle across edges
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i);
      {cs_ni, dir_i, mbx_sel_i} = 3'(k * 5);
      en_i = 1'b0; data_i = DW'(k);
      #2 dir_i = ~dir_i;
      @(posedge clk_i); #1 cs_ni = ~cs_ni;
    end
    @(negedge clk_i);
    idle();
    @(negedge clk_i);
    chk("R10 no strobe", DW'(fifo_rd_o), '0);
    chk("R10 mb1 flag kept", DW'(mb1_full_no), '0);
    chk("R10 mb2 data kept", mb2_q_o, mb2_m);
    chk("R10 mb2 flag kept", DW'(mb2_full_o), DW'(1));

    // R11 reset while loaded, with a read in flight
    cs_ni = 1'b0; dir_i = 1'b1; en_i = 1'b1; mbx_sel_i = 1'b0;
    @(negedge clk_i);
    chk("R5 strobe before reset", DW'(fifo_rd_o), DW'(1));
    rst_ni = 1'b0;
    #1;
    chk("R11 strobe cleared", DW'(fifo_rd_o), '0);
    chk("R11 mb1 flag", DW'(mb1_full_no), DW'(1));
    chk("R11 mb2 flag", DW'(mb2_full_o), '0);
    chk("R11 mb2 data", mb2_q_o, '0);
    idle();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule